// File: doc/BRIEF.md
# Dual Decade Divider Pulse Generator

This block accepts two square waves of nominally 100 kHz that arrive asynchronously to the system clock. One is the measurement IF, which carries the multiplied frequency difference. The other is the unmultiplied reference. Each wave passes through its own synchroniser and edge detector. It then enters a divider chain. Both chains are built from the same module and share the same divisor, so they divide alike and have the same latency. The divisor is picked in decade steps. With the default parameters the output runs from 1 kHz down to 1 mHz, which is division by 10^2 up to 10^8.

Every terminal count of a chain triggers a clocked one-shot, which emits a fixed-width pulse. At the default 10 MHz clock this pulse is 100 cycles, or 10 µs. The one-shot is a two-state machine:
- `OS_IDLE` moves to `OS_HOLD` on a trigger. This transition is called *arm*.
- `OS_HOLD` moves back to `OS_IDLE` when its remaining-cycle counter has reached zero. This transition is called *expire*.
- Either state moves to `OS_IDLE` when the divider selection changes. This transition is called *abort*.

A mode input decides what reaches the two counter outputs:
- Phase mode routes the measurement and reference pulse trains.
- Frequency mode routes the synchronised square waves themselves.

Top module: `decade_pulse_router`

## Requirements
- R1: While `rst_ni` is low, and until the first divided edge after reset, both counter outputs are low and both chains hold a count of zero.
- R2: Each input is sampled by SYNC_STAGES flops (2 by default). Only a low-to-high transition of the synchronised level advances a chain, exactly once per transition.
- R3: Selection value k, for k from 0 to NUM_SEL-1, divides by RADIX^(MIN_EXP+k). Any value of NUM_SEL or above uses the largest divisor. The defaults are RADIX=10, MIN_EXP=2 and NUM_SEL=7, which give division by 10^2 through 10^8. The first pulse comes on the divisor-th rising edge after a clear.
- R4: Every pulse that is not aborted is high for exactly PULSE_CYCLES consecutive clock cycles (100 by default).
- R5: With the default two stages, the pulse output is first seen high after the third rising clock edge that samples the divisor-th input high.
- R6: A trigger that arrives while a pulse is active is dropped. It neither restarts nor lengthens the pulse, and the next trigger that arrives in `OS_IDLE` is accepted.
- R7: When both inputs carry the same waveform, outputs A and B are equal in every cycle in phase mode.
- R8: A change of `dec_sel_i` clears both chains and aborts any pulse at the next clock edge. No pulse follows until the new divisor's count of rising edges has been seen.
- R9: In phase mode (`phase_mode_i` = 1), A carries the measurement pulses and B carries the reference pulses, even when the two inputs run at different rates.
- R10: In frequency mode (`phase_mode_i` = 0), A is the synchronised measurement level and B is the synchronised reference level. Each is delayed by SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (10 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_sq_i | input | 1 | Squared measurement IF, asynchronous |
| ref_sq_i | input | 1 | Squared unmultiplied reference, asynchronous |
| dec_sel_i | input | SEL_W | Decade selection (clog2 of NUM_SEL bits) |
| phase_mode_i | input | 1 | 1 = phase mode (pulse trains), 0 = frequency mode (square waves) |
| cnt_a_o | output | 1 | Counter channel A |
| cnt_b_o | output | 1 | Counter channel B |

## Verification
A selection change can land in the same cycle as a pulse that is still being emitted, or while both chains hold partial counts that already exceed the new terminal value. The bench provokes both cases:
- It first leaves eight edges pending under a divisor of nine, then switches to a divisor of three. It checks that two more edges produce nothing and that the third edge produces exactly one pulse.
- It then changes the selection in the middle of that pulse, and expects both outputs low one edge later.

A second coincidence is a divided trigger that arrives while the one-shot is still in `OS_HOLD`. Fast inputs provoke it, and the bench judges it by the pulse count (every other trigger) and by the pulse widths, which must stay unchanged.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_HOLD = 1'b1
    } os_state_e;

    // Integer power used to build the divisor table at elaboration.
    function automatic longint unsigned ipow(input int unsigned base, input int unsigned e);
        longint unsigned acc;
        acc = 1;
        for (int unsigned i = 0; i < e; i++) begin
            acc = acc * base;
        end
        return acc;
    endfunction

endpackage

// File: rtl/dpg_sync_edge.sv
module dpg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o
);

    // STAGES synchroniser flops plus one history flop for the edge detector.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], d_i};
        end
    end

    always_comb begin
        lvl_o  = sh_q[STAGES-1];
        rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    // R2: a detected edge lasts one cycle only.
    p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dpg_decade_div.sv
module dpg_decade_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_term;

    always_comb begin
        at_term = (cnt_q >= term_i);
        tick_o  = rise_i && !clr_i && at_term;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            if (at_term) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the count never passes the terminal value of the selected decade.
    p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |-> (cnt_q <= term_i));

endmodule

// File: rtl/dpg_oneshot.sv
module dpg_oneshot #(
    parameter int PULSE_CYCLES = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic trig_i,
    output logic pulse_o
);

    import dpg_pkg::*;

    localparam int              PW_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PW_W-1:0] LOAD = PW_W'(PULSE_CYCLES - 1);

    os_state_e       state_q, state_d;
    logic [PW_W-1:0] rem_q, rem_d;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= OS_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Transitions: arm, expire, abort.
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        if (clr_i) begin
            state_d = OS_IDLE;
            rem_d   = '0;
        end else begin
            unique case (state_q)
                OS_IDLE: begin
                    if (trig_i) begin
                        state_d = OS_HOLD;
                        rem_d   = LOAD;
                    end
                end
                OS_HOLD: begin
                    if (rem_q == '0) begin
                        state_d = OS_IDLE;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        pulse_o = (state_q == OS_HOLD);
    end

    // Run-length tracker used only by the checks below.
    logic [PW_W:0] hi_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run_q <= '0;
        end else if (pulse_o) begin
            hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
        end
    end

    // R4: a pulse never outlasts its width.
    p_width_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> (hi_run_q < (PW_W+1)'(PULSE_CYCLES)));

    // R4: an unaborted pulse is not cut short.
    p_width_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_o && !clr_i && (hi_run_q < (PW_W+1)'(PULSE_CYCLES - 1))) |=> pulse_o);

    // R6: a pulse only starts from a trigger seen in the previous cycle.
    p_start_trig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |-> $past(trig_i));

endmodule

// File: rtl/decade_pulse_router.sv
module decade_pulse_router #(
    parameter int RADIX        = 10,
    parameter int MIN_EXP      = 2,
    parameter int NUM_SEL      = 7,
    parameter int PULSE_CYCLES = 100,
    parameter int SYNC_STAGES  = 2,
    localparam int SEL_W       = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             if_sq_i,
    input  logic             ref_sq_i,
    input  logic [SEL_W-1:0] dec_sel_i,
    input  logic             phase_mode_i,
    output logic             cnt_a_o,
    output logic             cnt_b_o
);

    localparam longint unsigned MAX_DIV = dpg_pkg::ipow(RADIX, MIN_EXP + NUM_SEL - 1);
    localparam int              CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
    localparam int              N_CH    = 2;   // channel 0: measurement, channel 1: reference

    // Terminal values, one per decade setting.
    logic [CNT_W-1:0] term_tab [NUM_SEL];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
        assign term_tab[g] = CNT_W'(dpg_pkg::ipow(RADIX, MIN_EXP + g) - 1);
    end

    logic [SEL_W-1:0] sel_eff;
    logic [CNT_W-1:0] term_sel;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;

    always_comb begin
        if (int'(dec_sel_i) >= NUM_SEL) begin
            sel_eff = SEL_W'(NUM_SEL - 1);
        end else begin
            sel_eff = dec_sel_i;
        end
        term_sel = term_tab[sel_eff];
        sel_chg  = (dec_sel_i != sel_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else begin
            sel_q <= dec_sel_i;
        end
    end

    logic [N_CH-1:0] raw_vec, lvl_vec, rise_vec, tick_vec, pulse_vec;

    assign raw_vec = {ref_sq_i, if_sq_i};

    // Two identical chains, so both channels share division and latency.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        dpg_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (raw_vec[ch]),
            .lvl_o  (lvl_vec[ch]),
            .rise_o (rise_vec[ch])
        );

        dpg_decade_div #(
            .CNT_W (CNT_W)
        ) u_div (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (sel_chg),
            .rise_i (rise_vec[ch]),
            .term_i (term_sel),
            .tick_o (tick_vec[ch])
        );

        dpg_oneshot #(
            .PULSE_CYCLES (PULSE_CYCLES)
        ) u_shot (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (sel_chg),
            .trig_i  (tick_vec[ch]),
            .pulse_o (pulse_vec[ch])
        );
    end

    // Counter routing.
    always_comb begin
        if (phase_mode_i) begin
            cnt_a_o = pulse_vec[0];
            cnt_b_o = pulse_vec[1];
        end else begin
            cnt_a_o = lvl_vec[0];
            cnt_b_o = lvl_vec[1];
        end
    end

    // R8: a selection change leaves both one-shots idle after the next edge.
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_chg |=> (pulse_vec == '0));

endmodule

// File: tb/sim_decade_pulse_router.sv
module sim_decade_pulse_router;

    localparam int RADIX = 3;
    localparam int MINE  = 1;
    localparam int NSEL  = 3;
    localparam int PW    = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       if_sq = 1'b0;
    logic       ref_sq = 1'b0;
    logic [1:0] dec_sel = 2'd0;
    logic       phase_mode = 1'b1;
    logic       cnt_a, cnt_b;

    int checks = 0;
    int fails = 0;

    // Monitor state.
    int a_pulses = 0, b_pulses = 0, a_run = 0, b_run = 0;
    int width_bad = 0, lock_bad = 0;
    bit a_prev = 0, b_prev = 0, mon_width = 1, mon_lock = 0;

    always #10 clk = ~clk;

    decade_pulse_router #(
        .RADIX        (RADIX),
        .MIN_EXP      (MINE),
        .NUM_SEL      (NSEL),
        .PULSE_CYCLES (PW),
        .SYNC_STAGES  (2)
    ) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .if_sq_i      (if_sq),
        .ref_sq_i     (ref_sq),
        .dec_sel_i    (dec_sel),
        .phase_mode_i (phase_mode),
        .cnt_a_o      (cnt_a),
        .cnt_b_o      (cnt_b)
    );

    always @(negedge clk) begin
        if (cnt_a) begin
            if (!a_prev) a_pulses++;
            a_run++;
        end else if (a_prev) begin
            if (mon_width && a_run != PW) width_bad++;
            a_run = 0;
        end
        if (cnt_b) begin
            if (!b_prev) b_pulses++;
            b_run++;
        end else if (b_prev) begin
            if (mon_width && b_run != PW) width_bad++;
            b_run = 0;
        end
        if (mon_lock && (cnt_a != cnt_b)) lock_bad++;
        a_prev = cnt_a;
        b_prev = cnt_b;
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clr_mon();
        a_pulses = 0; b_pulses = 0; a_run = 0; b_run = 0;
        width_bad = 0; lock_bad = 0;
    endtask

    function automatic int exp_div(input int s);
        int e;
        int d;
        e = ((s >= NSEL) ? NSEL - 1 : s) + MINE;
        d = 1;
        for (int k = 0; k < e; k++) d = d * RADIX;
        return d;
    endfunction

    // Square waves starting high; half period 0 keeps that input low.
    task automatic drive_cycles(input int cycles, input int hm, input int hr);
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            if_sq  = (hm > 0) ? ((t % (2 * hm)) < hm) : 1'b0;
            ref_sq = (hr > 0) ? ((t % (2 * hr)) < hr) : 1'b0;
        end
        @(negedge clk);
        if_sq  = 1'b0;
        ref_sq = 1'b0;
    endtask

    task automatic settle();
        repeat (PW + 8) @(negedge clk);
    endtask

    task automatic reselect(input int v);
        @(negedge clk);
        dec_sel = (v == 0) ? 2'd1 : 2'd0;
        repeat (2) @(negedge clk);
        dec_sel = 2'(v);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, all requirements unresolved");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int d;
        // R1: outputs low in reset and just after.
        repeat (3) @(negedge clk);
        chk("R1 cnt_a in reset", cnt_a, 0);
        chk("R1 cnt_b in reset", cnt_b, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 cnt_a after reset", cnt_a, 0);
        chk("R1 cnt_b after reset", cnt_b, 0);

        // R3 R4 R7 R9: every selection including out of range, identical inputs.
        for (int s = 0; s < 4; s++) begin
            d = exp_div(s);
            reselect(s);
            clr_mon();
            mon_lock = 1;
            drive_cycles((3 * d + 2) * 8, 4, 4);
            settle();
            mon_lock = 0;
            chk($sformatf("R3 pulses on A, sel %0d", s), a_pulses, 3);
            chk($sformatf("R9 pulses on B, sel %0d", s), b_pulses, 3);
            chk($sformatf("R7 A/B lockstep, sel %0d", s), lock_bad, 0);
            chk($sformatf("R4 pulse widths, sel %0d", s), width_bad, 0);
        end

        // R5 and R2: latency from the third input edge at divisor 3.
        reselect(0);
        clr_mon();
        drive_cycles(16, 4, 0);
        chk("R2 no pulse before third edge", a_pulses, 0);
        @(negedge clk);
        if_sq = 1'b1;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (cnt_a) break;
        end
        chk("R5 edges to first pulse", n, 3);
        repeat (3) @(negedge clk);
        if_sq = 1'b0;
        settle();
        chk("R4 latency pulse width", width_bad, 0);

        // R6: triggers every 12 cycles against a 20-cycle pulse.
        reselect(0);
        clr_mon();
        drive_cycles(18 * 4, 2, 0);
        settle();
        chk("R6 retriggers ignored, pulse count", a_pulses, 3);
        chk("R6 widths unchanged", width_bad, 0);

        // R8: pending counts cleared by a selection change.
        reselect(1);
        clr_mon();
        drive_cycles(64, 4, 4);
        chk("R8 no pulse before divisor 9 reached", a_pulses, 0);
        dec_sel = 2'd0;
        repeat (2) @(negedge clk);
        clr_mon();
        drive_cycles(16, 4, 4);
        chk("R8 no pulse after 2 edges of new divisor", a_pulses + b_pulses, 0);
        drive_cycles(8, 4, 4);
        chk("R8 A pulse after full new period", a_pulses, 1);
        chk("R8 B pulse after full new period", b_pulses, 1);
        // R8: abort a pulse in flight.
        mon_width = 0;
        chk("R8 pulse active before abort", int'(cnt_a), 1);
        dec_sel = 2'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R8 A low after abort", int'(cnt_a), 0);
        chk("R8 B low after abort", int'(cnt_b), 0);
        settle();
        clr_mon();
        mon_width = 1;

        // R10: frequency mode passes the synchronised levels.
        phase_mode = 1'b0;
        repeat (4) @(negedge clk);
        if_sq = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 A still low after one edge", int'(cnt_a), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 A high after two edges", int'(cnt_a), 1);
        if_sq = 1'b0;
        repeat (6) @(negedge clk);
        clr_mon();
        mon_width = 0;
        drive_cycles(48, 4, 2);
        repeat (6) @(negedge clk);
        chk("R10 A follows measurement edges", a_pulses, 6);
        chk("R10 B follows reference edges", b_pulses, 12);
        mon_width = 1;

        // R9: phase mode with different input rates.
        phase_mode = 1'b1;
        reselect(0);
        clr_mon();
        drive_cycles(96, 4, 8);
        settle();
        chk("R9 A carries measurement pulses", a_pulses, 4);
        chk("R9 B carries reference pulses", b_pulses, 2);
        chk("R4 widths at mixed rates", width_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule